// File: doc/BRIEF.md
# Level/Edge Interrupt Collector with IRQ and FIQ Steering

This block gathers interrupt requests from 26 sources and presents them to a processor on two request lines: a normal request (IRQ) and a fast request (FIQ). Six sources come from pins outside the chip and are asynchronous to the system clock. Twenty sources come from on-chip peripherals that are already synchronous. Each source has its own trigger type (level or edge), its own mask bit and its own choice of output line.

Software sets up the sources through a small register port with four registers: trigger type, mask, routing, and pending status with write-one-to-clear. For each output line the block also reports the number of the lowest-numbered source that is currently requesting it. An interrupt handler can read that index and skip scanning the pending register.

Source numbering: external inputs `ext_irq_in[k]` are sources 0 to 5. Internal inputs `int_irq_in[j]` are sources 6+j, which gives 6 to 25. Register bit n always refers to source n.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, the following state holds: every mask bit is 1, so the mask register reads 0x03FFFFFF. Every routing bit and every trigger-type bit is 0, and every pending bit is 0. Both request lines are low and both indices are 0.
- R2: An external input passes through two synchronizer flops before it reaches the pending logic. If an external input is driven high between two clock edges, the request line it reaches rises after the fourth following edge and not before.
- R3: A source whose trigger-type bit is 1 is edge-triggered. A rising edge on its input sets its pending bit, and the bit stays set after the input falls.
- R4: Writing to the pending register clears exactly those edge-triggered pending bits for which the written data bit is 1. Zero bits leave their pending bits unchanged. If a rising edge and a clear reach the same bit in the same cycle, the bit ends up set.
- R5: A source whose trigger-type bit is 0 is level-triggered. Its pending bit follows its input one cycle later, and a write-one-to-clear has no effect on it.
- R6: A source whose mask bit is 1 still shows in the pending register but drives neither request line.
- R7: An unmasked pending source drives FIQ when its routing bit is 1 and IRQ when its routing bit is 0.
- R8: Each index output gives the lowest-numbered unmasked pending source routed to that line. The index is 0 when its line is low. The line and its index are registered and follow the pending state one cycle later.
- R9: Register addresses are 0 for trigger type, 1 for mask, 2 for routing and 3 for pending. Read data appears one cycle after the address is presented. Data bits 26 to 31 are ignored on write and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq_in | input | 6 | Asynchronous external requests, sources 0 to 5 |
| int_irq_in | input | 20 | Synchronous internal requests, sources 6 to 25 |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register write address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 2 | Register read address |
| reg_rd_data | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| irq_idx_o | output | 5 | Lowest active IRQ source |
| fiq_o | output | 1 | Fast interrupt request |
| fiq_idx_o | output | 5 | Lowest active FIQ source |

## Verification
One internal source is driven in turn as a held level, as a one-cycle pulse in edge mode, and as a pulse that arrives in the same cycle as a clear. Together these separate level-following, edge latching, the clear and which of set or clear wins. Several sources are then raised and dropped in overlapping order, one of them masked and some routed to each line, which tells apart mask gating, steering and the lowest-index choice as the winner changes. An external input is timed edge by edge to confirm the two synchronizer stages, and a short external pulse in edge mode shows that a latched request survives the input falling.

// File: rtl/irq_fiq_pkg.sv
package irq_fiq_pkg;
  localparam int REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    SEL_TRIG  = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_ROUTE = 2'd2,
    SEL_PEND  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_in_sync.sv
module irq_in_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_fiq_pkg::*;
#(
  parameter int N  = 26,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  input  logic [N-1:0]      pend,
  output logic [N-1:0]      trig_q,
  output logic [N-1:0]      mask_q,
  output logic [N-1:0]      route_q,
  output logic [N-1:0]      clr,
  output logic [DW-1:0]     rd_data
);
  logic [N-1:0] wr_bits;
  assign wr_bits = wr_data[N-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q  <= '0;
      mask_q  <= '1;
      route_q <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_addr))
        SEL_TRIG:  trig_q  <= wr_bits;
        SEL_MASK:  mask_q  <= wr_bits;
        SEL_ROUTE: route_q <= wr_bits;
        default:   ;
      endcase
    end
  end

  assign clr = (wr_en && reg_sel_e'(wr_addr) == SEL_PEND) ? wr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (reg_sel_e'(rd_addr))
        SEL_TRIG:  rd_data <= DW'(trig_q);
        SEL_MASK:  rd_data <= DW'(mask_q);
        SEL_ROUTE: rd_data <= DW'(route_q);
        default:   rd_data <= DW'(pend);
      endcase
    end
  end

  // R1: configuration returns to its reset values
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (mask_q == '1 && route_q == '0 && trig_q == '0));
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int N = 26
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend_q
);
  logic [N-1:0] src_d;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        src_d[i]  <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        src_d[i] <= src[i];
        if (trig[i]) pend_q[i] <= (pend_q[i] & ~clr[i]) | (src[i] & ~src_d[i]);
        else         pend_q[i] <= src[i];
      end
    end
  end

  // R3: latched edge requests survive unless cleared
  assert_edge_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (($past(pend_q) & $past(trig) & trig & ~$past(clr)) & ~pend_q) == '0);

  // R5: level requests track the input one cycle later
  assert_level_follow_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (((pend_q ^ $past(src)) & ~$past(trig)) == '0));
endmodule

// File: rtl/irq_lowest_enc.sv
module irq_lowest_enc #(
  parameter int N     = 26,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req,
  output logic             valid_q,
  output logic [IDX_W-1:0] idx_q
);
  logic [IDX_W-1:0] idx_n;

  always_comb begin
    idx_n = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) idx_n = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      valid_q <= |req;
      idx_q   <= (|req) ? idx_n : '0;
    end
  end

  // R8: reported index was requesting and nothing lower was
  assert_lowest_idx_R8: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> ((($past(req) >> idx_q) & N'(1)) != '0 &&
                 ($past(req) & ((N'(1) << idx_q) - N'(1))) == '0));

  assert_idle_idx_R8: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> idx_q == '0);
endmodule

// File: rtl/irq_fiq_ctrl.sv
module irq_fiq_ctrl
  import irq_fiq_pkg::*;
#(
  parameter int N_EXT       = 6,
  parameter int N_INT       = 20,
  parameter int SYNC_STAGES = 2,
  parameter int DW          = 32,
  localparam int N_SRC      = N_EXT + N_INT,
  localparam int IDX_W      = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EXT-1:0]  ext_irq_in,
  input  logic [N_INT-1:0]  int_irq_in,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_wr_addr,
  input  logic [DW-1:0]     reg_wr_data,
  input  logic [REG_AW-1:0] reg_rd_addr,
  output logic [DW-1:0]     reg_rd_data,
  output logic              irq_o,
  output logic [IDX_W-1:0]  irq_idx_o,
  output logic              fiq_o,
  output logic [IDX_W-1:0]  fiq_idx_o
);
  logic [N_EXT-1:0] ext_s;
  logic [N_SRC-1:0] src, pend, trig, mask, route, clr;
  logic [N_SRC-1:0] act_irq, act_fiq;

  irq_in_sync #(.W(N_EXT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(ext_irq_in), .q(ext_s));

  assign src = {int_irq_in, ext_s};

  irq_regs #(.N(N_SRC), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_addr(reg_wr_addr),
    .wr_data(reg_wr_data), .rd_addr(reg_rd_addr), .pend(pend),
    .trig_q(trig), .mask_q(mask), .route_q(route), .clr(clr),
    .rd_data(reg_rd_data));

  irq_pend #(.N(N_SRC)) u_pend (
    .clk(clk), .rst(rst), .src(src), .trig(trig), .clr(clr), .pend_q(pend));

  assign act_irq = pend & ~mask & ~route;
  assign act_fiq = pend & ~mask & route;

  irq_lowest_enc #(.N(N_SRC), .IDX_W(IDX_W)) u_enc_irq (
    .clk(clk), .rst(rst), .req(act_irq), .valid_q(irq_o), .idx_q(irq_idx_o));

  irq_lowest_enc #(.N(N_SRC), .IDX_W(IDX_W)) u_enc_fiq (
    .clk(clk), .rst(rst), .req(act_fiq), .valid_q(fiq_o), .idx_q(fiq_idx_o));

  // R6: a line never reports a source that was masked
  assert_mask_gate_R6: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (($past(mask) >> irq_idx_o) & N_SRC'(1)) == '0);

  // R7: each line only reports sources steered to it
  assert_irq_route_R7: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (($past(route) >> irq_idx_o) & N_SRC'(1)) == '0);

  assert_fiq_route_R7: assert property (@(posedge clk) disable iff (rst)
    fiq_o |-> (($past(route) >> fiq_idx_o) & N_SRC'(1)) != '0);
endmodule

// File: tb/irq_fiq_ctrl_tb.sv
module irq_fiq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  ext_irq_in = '0;
  logic [19:0] int_irq_in = '0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_wr_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic [1:0]  reg_rd_addr = '0;
  logic [31:0] reg_rd_data;
  logic        irq_o, fiq_o;
  logic [4:0]  irq_idx_o, fiq_idx_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic       irq;
    logic [4:0] ii;
    logic       fiq;
    logic [4:0] fi;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  localparam logic [31:0] ALL = 32'h03FF_FFFF;

  always #10 clk = ~clk;

  irq_fiq_ctrl u_dut (
    .clk(clk), .rst(rst), .ext_irq_in(ext_irq_in), .int_irq_in(int_irq_in),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .irq_o(irq_o), .irq_idx_o(irq_idx_o), .fiq_o(fiq_o), .fiq_idx_o(fiq_idx_o));

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_check(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_rd_addr = a;
    @(negedge clk);
    check(reg_rd_data == exp, tag, reg_rd_data, exp);
  endtask

  // driver side of the scoreboard: push expectation, wait until consumed
  task automatic expect_out(input logic i, input logic [4:0] ii, input logic f,
                            input logic [4:0] fi, input string tag);
    exp_t e;
    e.irq = i; e.ii = ii; e.fiq = f; e.fi = fi; e.tag = tag;
    sb_q.push_back(e);
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  // monitor: let outputs settle, then compare against the queued item
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        repeat (5) @(negedge clk);
        e = sb_q.pop_front();
        check({irq_o, irq_idx_o, fiq_o, fiq_idx_o} == {e.irq, e.ii, e.fiq, e.fi},
              e.tag, {20'd0, irq_o, irq_idx_o, fiq_o, fiq_idx_o},
              {20'd0, e.irq, e.ii, e.fiq, e.fi});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check({irq_o, irq_idx_o, fiq_o, fiq_idx_o} == 12'd0, "R1 outputs after reset",
          {20'd0, irq_o, irq_idx_o, fiq_o, fiq_idx_o}, 32'd0);
    rd_check(2'd0, 32'd0, "R1 trigger type reset");
    rd_check(2'd1, ALL,   "R1 mask reset");
    rd_check(2'd2, 32'd0, "R1 routing reset");
    rd_check(2'd3, 32'd0, "R1 pending reset");
    // R9 upper bits ignored and read as zero
    wr(2'd1, 32'hFFFF_FFFF);
    rd_check(2'd1, ALL, "R9 unused bits read zero");

    // R6 masked level source: pending visible, lines quiet
    @(negedge clk); int_irq_in[4] = 1'b1;          // source 10
    rd_check(2'd3, 32'h400, "R6 masked source pending");
    expect_out(0, 0, 0, 0, "R6 masked source silent");
    wr(2'd1, ALL & ~32'h400);
    expect_out(1, 10, 0, 0, "R6 unmasked source on IRQ");

    // R5 level: clear ignored, follows input
    wr(2'd3, 32'h400);
    rd_check(2'd3, 32'h400, "R5 clear ignored for level");
    @(negedge clk); int_irq_in[4] = 1'b0;
    expect_out(0, 0, 0, 0, "R5 level drop releases IRQ");
    rd_check(2'd3, 32'd0, "R5 pending follows input");

    // R3 edge latch
    wr(2'd0, 32'h400);
    @(negedge clk); int_irq_in[4] = 1'b1;
    @(negedge clk); int_irq_in[4] = 1'b0;
    expect_out(1, 10, 0, 0, "R3 pulse latched");
    rd_check(2'd3, 32'h400, "R3 pending held after input falls");
    // R4 clear semantics
    wr(2'd3, 32'd0);
    rd_check(2'd3, 32'h400, "R4 zero write keeps pending");
    wr(2'd3, 32'h400);
    expect_out(0, 0, 0, 0, "R4 write one clears");
    rd_check(2'd3, 32'd0, "R4 pending cleared");
    // R4 set wins over simultaneous clear
    @(negedge clk);
    int_irq_in[4] = 1'b1;
    reg_wr_en = 1'b1; reg_wr_addr = 2'd3; reg_wr_data = 32'h400;
    @(negedge clk);
    reg_wr_en = 1'b0; int_irq_in[4] = 1'b0;
    rd_check(2'd3, 32'h400, "R4 set wins over clear");
    wr(2'd3, 32'h400);
    expect_out(0, 0, 0, 0, "R4 cleared after collision");

    // R7 routing and R8 lowest index
    wr(2'd2, 32'h1000);                            // source 12 to FIQ
    wr(2'd1, ALL & ~32'h0210_150C);                // unmask 2,3,8,10,12,20,25
    @(negedge clk); int_irq_in[6] = 1'b1;          // source 12
    expect_out(0, 0, 1, 12, "R7 routed source on FIQ only");
    @(negedge clk); int_irq_in[2] = 1'b1;          // source 8
    expect_out(1, 8, 1, 12, "R7 IRQ source beside FIQ source");
    @(negedge clk); int_irq_in[1] = 1'b1;          // source 7, masked
    expect_out(1, 8, 1, 12, "R6 masked lower source not reported");
    @(negedge clk); int_irq_in[14] = 1'b1;         // source 20
    expect_out(1, 8, 1, 12, "R8 lower index wins");
    @(negedge clk); int_irq_in[2] = 1'b0;
    expect_out(1, 20, 1, 12, "R8 next index after drop");
    @(negedge clk); int_irq_in[19] = 1'b1;         // source 25
    expect_out(1, 20, 1, 12, "R8 higher source does not displace");
    @(negedge clk); int_irq_in[14] = 1'b0;
    expect_out(1, 25, 1, 12, "R8 top source reported");
    @(negedge clk); int_irq_in[6] = 1'b0; int_irq_in[1] = 1'b0;
    expect_out(1, 25, 0, 0, "R7 FIQ released");

    // R2 synchronizer latency on external source 2
    wr(2'd2, 32'h1004);
    @(negedge clk); ext_irq_in[2] = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      check(fiq_o == 1'b0, "R2 FIQ not yet raised", {31'd0, fiq_o}, 32'd0);
    end
    @(negedge clk);
    check(fiq_o == 1'b1 && fiq_idx_o == 5'd2, "R2 FIQ after four edges",
          {26'd0, fiq_o, fiq_idx_o}, {26'd0, 1'b1, 5'd2});

    // R3 external edge source 3
    wr(2'd0, 32'h408);
    @(negedge clk); ext_irq_in[3] = 1'b1;
    @(negedge clk);
    @(negedge clk); ext_irq_in[3] = 1'b0;
    expect_out(1, 3, 1, 2, "R3 external edge latched");
    wr(2'd3, 32'h8);
    expect_out(1, 25, 1, 2, "R4 external edge cleared");
    @(negedge clk); ext_irq_in[2] = 1'b0; int_irq_in[19] = 1'b0;
    expect_out(0, 0, 0, 0, "R8 all idle index zero");

    finish_run();
  end
endmodule